// File: doc/BRIEF.md
# Clock Source Guard

This block produces the CPU clock from an oscillator input. Three strap pins are captured while the hardware reset is held. They choose between a divide-by-two clock, which is high for one oscillator period and low for the next, and a direct pass-through of the oscillator. Strap codes that name neither mode fall back to pass-through and raise a flag saying so.

A supervisor runs on an independent reference clock. It follows a toggle from the oscillator domain through a synchronizer and counts reference cycles in which no toggle edge arrives. When supervision is enabled and the count reaches a parameter limit, the supervisor does three things:
- it sets a sticky failure flag;
- it emits a one-cycle interrupt request in the reference domain;
- it moves the CPU clock onto the reference clock.

The switch is built so that no pulse shorter than a full source phase reaches the output. Once the CPU clock is on the reference clock it stays there until the next hardware reset, even if the oscillator starts again. While the enable input is low, a dead oscillator is tolerated without any request, and the CPU clock stays on the oscillator path.

Top module: `clk_src_guard`

## Requirements
- R1: With strap code 3'b001 captured at reset, cpu_clk has twice the oscillator period, and its high phase lasts exactly one oscillator period.
- R2: With strap code 3'b011 captured at reset, cpu_clk follows the oscillator with the same period and high time.
- R3: Any strap code other than 3'b001 and 3'b011 selects pass-through and drives mode_unsupported to 1. For 3'b001 and 3'b011, mode_unsupported is 0. The output holds its value until the next reset.
- R4: After reset release, fail_flag and fail_irq are 0 and cpu_clk comes from the oscillator path.
- R5: With sup_en = 1 and a running oscillator, fail_flag stays 0. After the oscillator stops, fail_flag rises no earlier than LOSS_CYCLES and no later than LOSS_CYCLES + 8 reference cycles.
- R6: fail_irq is high for exactly one reference cycle, and that cycle is the cycle in which fail_flag first reads 1.
- R7: After failover, cpu_clk follows ref_clk with the reference period and high time.
- R8: With sup_en = 0, a stopped oscillator produces no fail_irq and no fail_flag, and cpu_clk stays on the stalled oscillator path with no edges. If sup_en is then raised while the oscillator is still stopped, the failover follows within LOSS_CYCLES + 8 reference cycles.
- R9: After failover, restarting the oscillator neither clears fail_flag nor moves cpu_clk back. Only rst_n restores the oscillator source.
- R10: During failover, no high pulse on cpu_clk is shorter than half a reference period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock input |
| ref_clk | input | 1 | Independent reference clock used for supervision and as the fallback source |
| rst_n | input | 1 | Asynchronous hardware reset, active low; strap pins are captured while it is held |
| mode_pins | input | 3 | Strap pins: 3'b001 selects divide-by-two, 3'b011 selects pass-through |
| sup_en | input | 1 | Supervision enable from a configuration register, reference domain; 0 after reset |
| cpu_clk | output | 1 | Generated CPU clock |
| fail_irq | output | 1 | One-cycle oscillator-failure request, reference domain |
| fail_flag | output | 1 | Sticky indication that the CPU clock has moved to the reference clock |
| mode_unsupported | output | 1 | High when the captured strap code is not a defined mode |

## Verification
The hardest situation to reach is the hand-over itself. The oscillator has to stall at a chosen level, and the reference clock then has to take over without a runt pulse.

The bench owns the oscillator generator and can freeze it right after a rising edge, leaving the oscillator stuck high. In pass-through mode this forces the cut-off to truncate a stretched high phase. A monitor on cpu_clk records every high-pulse width across the switch.

The disabled-then-enabled sequence lets the stall counter saturate before supervision is allowed. This shows that a loss seen earlier still leads to failover as soon as supervision is allowed. Restarting the oscillator after failover shows that the choice is sticky.

// File: rtl/clkguard_pkg.sv
`timescale 1ns/1ps
package clkguard_pkg;

  localparam logic [2:0] STRAP_HALF = 3'b001;
  localparam logic [2:0] STRAP_PASS = 3'b011;

  typedef enum logic {
    SRC_HALF = 1'b0,
    SRC_PASS = 1'b1
  } osc_mode_e;

  typedef struct packed {
    osc_mode_e mode;
    logic      unsupported;
  } strap_dec_t;

  // Strap decoding: undefined codes fall back to pass-through and are flagged.
  function automatic strap_dec_t decode_strap(input logic [2:0] code);
    strap_dec_t d;
    case (code)
      STRAP_HALF: begin d.mode = SRC_HALF; d.unsupported = 1'b0; end
      STRAP_PASS: begin d.mode = SRC_PASS; d.unsupported = 1'b0; end
      default:    begin d.mode = SRC_PASS; d.unsupported = 1'b1; end
    endcase
    return d;
  endfunction

  // Width of a counter that must hold the value 0..limit.
  function automatic int idle_cnt_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/cdc_sync.sv
`timescale 1ns/1ps
module cdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];

endmodule

// File: rtl/osc_prescaler.sv
`timescale 1ns/1ps
module osc_prescaler #(
  parameter int TOG_W = 1
) (
  input  logic osc_clk,
  input  logic rst_osc_n,
  input  logic pass_mode,
  output logic osc_src,
  output logic osc_tog
);

  logic             half_q;
  logic [TOG_W-1:0] tog_cnt;

  always_ff @(posedge osc_clk or negedge rst_osc_n) begin
    if (!rst_osc_n) begin
      half_q  <= 1'b0;
      tog_cnt <= '0;
    end else begin
      half_q  <= ~half_q;
      tog_cnt <= tog_cnt + TOG_W'(1);
    end
  end

  // Divide-by-two output has one full oscillator period per phase.
  assign osc_src = pass_mode ? osc_clk : half_q;
  // The top bit of the counter is the activity signal seen by the supervisor.
  assign osc_tog = tog_cnt[TOG_W-1];

endmodule

// File: rtl/osc_loss_monitor.sv
`timescale 1ns/1ps
module osc_loss_monitor #(
  parameter int LOSS_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_ref_n,
  input  logic osc_tog,
  input  logic sup_en,
  output logic fail_flag,
  output logic fail_irq
);

  localparam int                CNT_W = clkguard_pkg::idle_cnt_width(LOSS_CYCLES);
  localparam logic [CNT_W-1:0]  LIMIT = CNT_W'(LOSS_CYCLES);

  logic             tog_s;
  logic             tog_prev;
  logic             tog_edge;
  logic [CNT_W-1:0] idle_cnt;
  logic             osc_lost;
  logic             fail_set;

  cdc_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
    .clk    (ref_clk),
    .arst_n (rst_ref_n),
    .d      (osc_tog),
    .q      (tog_s)
  );

  always_ff @(posedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n) tog_prev <= 1'b0;
    else            tog_prev <= tog_s;
  end

  assign tog_edge = tog_s ^ tog_prev;

  // Saturating count of reference cycles since the last oscillator activity.
  always_ff @(posedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n)             idle_cnt <= '0;
    else if (tog_edge)          idle_cnt <= '0;
    else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + CNT_W'(1);
  end

  assign osc_lost = (idle_cnt == LIMIT);
  assign fail_set = osc_lost & sup_en & ~fail_flag;

  always_ff @(posedge ref_clk or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      fail_flag <= 1'b0;
      fail_irq  <= 1'b0;
    end else begin
      fail_flag <= fail_flag | fail_set;
      fail_irq  <= fail_set;
    end
  end

endmodule

// File: rtl/clk_switch.sv
`timescale 1ns/1ps
module clk_switch #(
  parameter int GATE_STAGES = 2
) (
  input  logic osc_src,
  input  logic ref_clk,
  input  logic rst_ref_n,
  input  logic to_ref,
  output logic cpu_clk
);

  logic [GATE_STAGES-1:0] gate_sh;
  logic                   ref_gate;
  logic                   osc_gate;

  // The reference enable advances only on reference falling edges, so it
  // opens while ref_clk is low and the first passed pulse is a full phase.
  generate
    if (GATE_STAGES == 1) begin : g_single
      always_ff @(negedge ref_clk or negedge rst_ref_n) begin
        if (!rst_ref_n) gate_sh <= '0;
        else            gate_sh <= to_ref;
      end
    end else begin : g_chain
      always_ff @(negedge ref_clk or negedge rst_ref_n) begin
        if (!rst_ref_n) gate_sh <= '0;
        else            gate_sh <= {gate_sh[GATE_STAGES-2:0], to_ref};
      end
    end
  endgenerate

  assign ref_gate = gate_sh[GATE_STAGES-1];
  // Failover is declared only after the oscillator has been still for many
  // reference cycles, so removing its path can only end a stretched phase.
  assign osc_gate = ~to_ref;
  assign cpu_clk  = (osc_src & osc_gate) | (ref_clk & ref_gate);

endmodule

// File: rtl/clk_src_guard.sv
`timescale 1ns/1ps
module clk_src_guard #(
  parameter int LOSS_CYCLES = 8,
  parameter int TOG_W       = 1,
  parameter int SYNC_STAGES = 2,
  parameter int GATE_STAGES = 2
) (
  input  logic       osc_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [2:0] mode_pins,
  input  logic       sup_en,
  output logic       cpu_clk,
  output logic       fail_irq,
  output logic       fail_flag,
  output logic       mode_unsupported
);

  import clkguard_pkg::*;

  logic       rst_osc_n;
  logic       rst_ref_n;
  logic [2:0] strap_q;
  strap_dec_t strap_dec;
  logic       pass_mode;
  logic       osc_src;
  logic       osc_tog;

  cdc_sync #(.STAGES(SYNC_STAGES)) u_rst_osc (
    .clk    (osc_clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (rst_osc_n)
  );

  cdc_sync #(.STAGES(SYNC_STAGES)) u_rst_ref (
    .clk    (ref_clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (rst_ref_n)
  );

  // Strap capture: loaded on every reference edge while reset is held.
  always_ff @(posedge ref_clk) begin
    if (!rst_ref_n) strap_q <= mode_pins;
  end

  assign strap_dec        = decode_strap(strap_q);
  assign pass_mode        = (strap_dec.mode == SRC_PASS);
  assign mode_unsupported = strap_dec.unsupported;

  osc_prescaler #(.TOG_W(TOG_W)) u_pre (
    .osc_clk   (osc_clk),
    .rst_osc_n (rst_osc_n),
    .pass_mode (pass_mode),
    .osc_src   (osc_src),
    .osc_tog   (osc_tog)
  );

  osc_loss_monitor #(
    .LOSS_CYCLES (LOSS_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mon (
    .ref_clk   (ref_clk),
    .rst_ref_n (rst_ref_n),
    .osc_tog   (osc_tog),
    .sup_en    (sup_en),
    .fail_flag (fail_flag),
    .fail_irq  (fail_irq)
  );

  clk_switch #(.GATE_STAGES(GATE_STAGES)) u_sw (
    .osc_src   (osc_src),
    .ref_clk   (ref_clk),
    .rst_ref_n (rst_ref_n),
    .to_ref    (fail_flag),
    .cpu_clk   (cpu_clk)
  );

endmodule

// File: rtl/clk_src_guard_chk.sv
`timescale 1ns/1ps
module clk_src_guard_chk (
  input logic ref_clk,
  input logic rst_ref_n,
  input logic sup_en,
  input logic osc_lost,
  input logic fail_flag,
  input logic fail_irq
);

  assert_irq_single_R6: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    fail_irq |=> !fail_irq);

  assert_irq_with_flag_R6: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    $rose(fail_flag) |-> fail_irq);

  assert_flag_sticky_R9: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    fail_flag |=> fail_flag);

  assert_fail_needs_enable_R8: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    $rose(fail_flag) |-> $past(sup_en));

  assert_fail_needs_loss_R5: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    $rose(fail_flag) |-> $past(osc_lost));

endmodule

bind osc_loss_monitor clk_src_guard_chk u_chk (
  .ref_clk   (ref_clk),
  .rst_ref_n (rst_ref_n),
  .sup_en    (sup_en),
  .osc_lost  (osc_lost),
  .fail_flag (fail_flag),
  .fail_irq  (fail_irq)
);

// File: tb/sim_clk_src_guard.sv
`timescale 1ns/1ps
module sim_clk_src_guard;

  localparam int LOSS = 8;

  logic       osc_clk;
  logic       ref_clk;
  logic       rst_n;
  logic [2:0] mode_pins;
  logic       sup_en;
  logic       cpu_clk;
  logic       fail_irq;
  logic       fail_flag;
  logic       mode_unsupported;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  osc_run = 1'b1;
  int  osc_half = 12;

  clk_src_guard #(.LOSS_CYCLES(LOSS)) u0 (
    .osc_clk          (osc_clk),
    .ref_clk          (ref_clk),
    .rst_n            (rst_n),
    .mode_pins        (mode_pins),
    .sup_en           (sup_en),
    .cpu_clk          (cpu_clk),
    .fail_irq         (fail_irq),
    .fail_flag        (fail_flag),
    .mode_unsupported (mode_unsupported)
  );

  initial begin
    ref_clk = 1'b0;
    forever #5 ref_clk = ~ref_clk;
  end

  initial begin
    osc_clk = 1'b0;
    forever begin
      #(osc_half);
      if (osc_run) osc_clk = ~osc_clk;
    end
  end

  // High-pulse width monitor and edge counter on the CPU clock.
  realtime rise_t = 0.0;
  realtime min_hi = 1.0e9;
  bit      arm = 1'b0;
  int      cpu_edges = 0;

  always @(posedge cpu_clk) begin
    rise_t = $realtime;
    cpu_edges++;
  end

  always @(negedge cpu_clk) begin
    if (arm && (($realtime - rise_t) < min_hi)) min_hi = $realtime - rise_t;
  end

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic chk_time(input string req, input realtime act, input realtime exp);
    n_chk++;
    if (act < exp - 0.5 || act > exp + 0.5) begin
      n_fail++;
      $display("FAIL %s: actual %0.2f ns expected %0.2f ns", req, act, exp);
    end
  endtask

  task automatic measure(output realtime hi, output realtime per);
    realtime t0, t1, t2;
    @(posedge cpu_clk);
    @(posedge cpu_clk); t0 = $realtime;
    @(negedge cpu_clk); t1 = $realtime;
    @(posedge cpu_clk); t2 = $realtime;
    hi  = t1 - t0;
    per = t2 - t0;
  endtask

  task automatic do_reset(input logic [2:0] strap);
    rst_n     = 1'b0;
    mode_pins = strap;
    sup_en    = 1'b0;
    osc_run   = 1'b1;
    repeat (6) @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (10) @(negedge ref_clk);
  endtask

  task automatic t_reset_div2();
    realtime hi, per;
    do_reset(3'b001);
    chk_bit("R4 flag after reset", fail_flag, 1'b0);
    chk_bit("R4 irq after reset", fail_irq, 1'b0);
    chk_bit("R3 unsupported for 001", mode_unsupported, 1'b0);
    measure(hi, per);
    chk_time("R1 half-rate high time", hi, 2.0 * osc_half);
    chk_time("R1 half-rate period", per, 4.0 * osc_half);
    chk_time("R4 oscillator source after reset", per, 4.0 * osc_half);
  endtask

  task automatic t_direct();
    realtime hi, per;
    do_reset(3'b011);
    chk_bit("R3 unsupported for 011", mode_unsupported, 1'b0);
    measure(hi, per);
    chk_time("R2 pass-through high time", hi, 1.0 * osc_half);
    chk_time("R2 pass-through period", per, 2.0 * osc_half);
  endtask

  task automatic t_unsupported(input logic [2:0] strap);
    realtime hi, per;
    do_reset(strap);
    chk_bit("R3 unsupported strap flagged", mode_unsupported, 1'b1);
    measure(hi, per);
    chk_time("R3 fallback to pass-through", per, 2.0 * osc_half);
    mode_pins = 3'b001;
    repeat (5) @(negedge ref_clk);
    chk_bit("R3 flag holds after pins change", mode_unsupported, 1'b1);
  endtask

  task automatic t_failover();
    realtime hi, per;
    int irq_cnt = 0;
    int first = -1;
    logic irq_at_first = 1'b0;
    do_reset(3'b011);
    sup_en = 1'b1;
    repeat (40) @(negedge ref_clk);
    chk_bit("R5 no failure while running", fail_flag, 1'b0);
    min_hi = 1.0e9;
    arm = 1'b1;
    @(posedge osc_clk);
    #1 osc_run = 1'b0;
    for (int i = 0; i < LOSS + 16; i++) begin
      @(negedge ref_clk);
      if (fail_irq) irq_cnt++;
      if (fail_flag && first < 0) begin
        first = i;
        irq_at_first = fail_irq;
      end
    end
    chk_int("R5 failure latency", first, LOSS, LOSS + 8);
    chk_int("R6 single request pulse", irq_cnt, 1, 1);
    chk_bit("R6 request with first flag cycle", irq_at_first, 1'b1);
    measure(hi, per);
    arm = 1'b0;
    chk_time("R7 reference high time", hi, 5.0);
    chk_time("R7 reference period", per, 10.0);
    n_chk++;
    if (min_hi < 4.5) begin
      n_fail++;
      $display("FAIL R10: actual min high %0.2f ns expected >= 4.50 ns", min_hi);
    end
  endtask

  task automatic t_disabled_then_sticky();
    realtime hi, per;
    int irq_cnt = 0;
    int first = -1;
    int edges0;
    do_reset(3'b001);
    @(posedge osc_clk);
    #1 osc_run = 1'b0;
    repeat (3) @(negedge ref_clk);
    edges0 = cpu_edges;
    for (int i = 0; i < 40; i++) begin
      @(negedge ref_clk);
      if (fail_irq) irq_cnt++;
    end
    chk_int("R8 no request while disabled", irq_cnt, 0, 0);
    chk_bit("R8 no flag while disabled", fail_flag, 1'b0);
    chk_int("R8 clock stays on stalled oscillator", cpu_edges - edges0, 0, 0);
    sup_en = 1'b1;
    for (int i = 0; i < LOSS + 16; i++) begin
      @(negedge ref_clk);
      if (fail_flag && first < 0) first = i;
    end
    chk_int("R8 late enable fails over", first, 0, LOSS + 8);
    // R9: oscillator recovery must not undo the failover.
    osc_run = 1'b1;
    repeat (50) @(negedge ref_clk);
    chk_bit("R9 flag sticky after recovery", fail_flag, 1'b1);
    measure(hi, per);
    chk_time("R9 still on reference", per, 10.0);
    do_reset(3'b001);
    chk_bit("R9 reset clears flag", fail_flag, 1'b0);
    measure(hi, per);
    chk_time("R9 reset restores oscillator", per, 4.0 * osc_half);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    mode_pins = 3'b001;
    sup_en    = 1'b0;
    t_reset_div2();
    t_direct();
    t_unsupported(3'b111);
    t_unsupported(3'b000);
    t_failover();
    t_disabled_then_sticky();
    finish_run();
  end

endmodule